// File: doc/BRIEF.md
# Leading/Trailing Zero and Population Count Unit

This block counts bits in one source operand. Three counts are available: the number of zeros above the highest set bit, the number of zeros below the lowest set bit, and the number of set bits. The operand is XLEN bits wide, and XLEN is a parameter set to 32 or 64. The count is returned zero-extended to XLEN bits. When XLEN is 64, a word flag in the operation select limits each count to bits 31..0 and ignores the upper half of the operand.

All three counts run through one adder tree. For the zero counts, the operand is first steered and, for the leading count, bit-reversed, so that the wanted count becomes a trailing-zero count. That trailing-zero count is then found by adding up the ones in a mask that covers every bit below the lowest set bit. The result is registered, so it appears one cycle after the request. Instruction decode and register writeback are done outside this block.

Top module: `bcnt_unit`

## Requirements
- R1: When op is 3'b000, the leading-zero count is returned. It is the number of zeros from bit XLEN-1 downward until the first 1, and a set top bit gives 0.
- R2: When op is 3'b001, the trailing-zero count is returned. It is the number of zeros from bit 0 upward until the first 1, and a set bit 0 gives 0.
- R3: When the operand is all zero, both the leading-zero and the trailing-zero count return XLEN.
- R4: When op is 3'b010, the number of 1 bits across the whole operand is returned.
- R5: When op is 3'b100 (word leading) or 3'b101 (word trailing), the scan covers only bits 31..0. The word leading scan starts at bit 31, and both word scans return 32 when bits 31..0 are zero.
- R6: When op is 3'b110, the number of 1 bits in bits 31..0 only is returned.
- R7: For the word ops, bits XLEN-1..32 of the source have no effect on the result.
- R8: The count sits in the low $clog2(XLEN)+1 bits of result, and every bit above it is zero.
- R9: Kind field op[1:0]=2'b11 is reserved. A word op (op[2]=1) is also illegal when XLEN is 32. An illegal op sets illegal=1 with result 0.
- R10: out_valid, result and illegal are registered one cycle after in_valid. out_valid is high exactly in the cycle after a request. Reset clears all three outputs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Request strobe |
| op | input | 3 | op[2] word flag, op[1:0] kind: 00 leading, 01 trailing, 10 population, 11 reserved |
| src | input | XLEN | Source operand |
| out_valid | output | 1 | Result valid, one cycle after in_valid |
| result | output | XLEN | Zero-extended count |
| illegal | output | 1 | Request used a reserved or unsupported op |

## Verification
Some properties are checked by assertions on every cycle: the one-cycle valid timing, the zero upper bits of the result, that an illegal op gives a zero result, and the zero-count cases at the top bit and bit 0. The all-zero operand is also checked this way, for both the full-width and the word leading count. The exact count for an arbitrary operand is shown only by the bench, which compares each result against a loop-based reference. The bench drives every single-bit operand, the all-zero and all-ones operands, and random values. It also shows that the upper half has no effect on the word ops, and that a 32-bit instance flags the word ops as illegal.

// File: rtl/bcnt_pkg.sv
package bcnt_pkg;

  typedef enum logic [1:0] {
    KIND_LEAD  = 2'd0,
    KIND_TRAIL = 2'd1,
    KIND_POP   = 2'd2,
    KIND_RSVD  = 2'd3
  } kind_e;

  localparam int OP_W   = 3;
  localparam int WORD_W = 32;

  // Word flag in bit 2 of the select.
  function automatic logic op_is_word(input logic [OP_W-1:0] op);
    return op[2];
  endfunction

  function automatic kind_e op_kind(input logic [OP_W-1:0] op);
    return kind_e'(op[1:0]);
  endfunction

  // Legal when the kind is defined and word ops have a wide datapath.
  function automatic logic op_legal(input logic [OP_W-1:0] op, input logic wide);
    return (op_kind(op) != KIND_RSVD) && (!op_is_word(op) || wide);
  endfunction

endpackage

// File: rtl/bcnt_steer.sv
module bcnt_steer
  import bcnt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic [OP_W-1:0] op,
  input  logic [XLEN-1:0] src,
  output logic [XLEN-1:0] count_vec,
  output logic            legal
);

  logic [XLEN-1:0] full_rev;
  logic [XLEN-1:0] word_lead;
  logic [XLEN-1:0] word_trail;
  logic [XLEN-1:0] word_pop;
  logic [XLEN-1:0] scan;
  logic [XLEN-1:0] below_mask;

  // Per-bit steering; positions above the word are padded so the
  // trailing scan stops at 32 and the population ignores them.
  for (genvar i = 0; i < XLEN; i++) begin : g_bit
    assign full_rev[i] = src[XLEN-1-i];
    if (i < WORD_W) begin : g_low
      assign word_lead[i]  = src[WORD_W-1-i];
      assign word_trail[i] = src[i];
      assign word_pop[i]   = src[i];
    end else begin : g_high
      assign word_lead[i]  = 1'b1;
      assign word_trail[i] = 1'b1;
      assign word_pop[i]   = 1'b0;
    end
  end

  always_comb begin
    legal = op_legal(op, XLEN == 64);
    unique case (op_kind(op))
      KIND_LEAD: scan = op_is_word(op) ? word_lead : full_rev;
      default:   scan = op_is_word(op) ? word_trail : src;
    endcase
    // Ones exactly at the positions below the lowest set bit.
    below_mask = ~scan & (scan - XLEN'(1));
    if (!legal) begin
      count_vec = '0;
    end else if (op_kind(op) == KIND_POP) begin
      count_vec = op_is_word(op) ? word_pop : src;
    end else begin
      count_vec = below_mask;
    end
  end

endmodule

// File: rtl/bcnt_adder_tree.sv
module bcnt_adder_tree #(
  parameter int W  = 64,
  localparam int LV = $clog2(W),
  localparam int CW = LV + 1
) (
  input  logic [W-1:0]  bits,
  output logic [CW-1:0] count
);

  for (genvar l = 0; l <= LV; l++) begin : g_lvl
    localparam int N = W >> l;
    logic [CW-1:0] sum [N];
    if (l == 0) begin : g_leaf
      for (genvar j = 0; j < N; j++) begin : g_in
        assign sum[j] = CW'(bits[j]);
      end
    end else begin : g_add
      for (genvar j = 0; j < N; j++) begin : g_pair
        assign sum[j] = g_lvl[l-1].sum[2*j] + g_lvl[l-1].sum[2*j+1];
      end
    end
  end

  assign count = g_lvl[LV].sum[0];

endmodule

// File: rtl/bcnt_unit.sv
module bcnt_unit
  import bcnt_pkg::*;
#(
  parameter int XLEN = 64
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            in_valid,
  input  logic [2:0]      op,
  input  logic [XLEN-1:0] src,
  output logic            out_valid,
  output logic [XLEN-1:0] result,
  output logic            illegal
);

  localparam int CW = $clog2(XLEN) + 1;

  logic [XLEN-1:0] count_vec;
  logic            op_ok;
  logic [CW-1:0]   tree_count;

  bcnt_steer #(.XLEN(XLEN)) u_steer (
    .op        (op),
    .src       (src),
    .count_vec (count_vec),
    .legal     (op_ok)
  );

  bcnt_adder_tree #(.W(XLEN)) u_tree (
    .bits  (count_vec),
    .count (tree_count)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      out_valid <= 1'b0;
      result    <= '0;
      illegal   <= 1'b0;
    end else begin
      out_valid <= in_valid;
      if (in_valid) begin
        result  <= XLEN'(tree_count);
        illegal <= !op_ok;
      end
    end
  end

  // R10: result appears exactly one cycle after the request
  a_r10_valid_follows: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid |=> out_valid);
  a_r10_no_spurious: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> !out_valid);
  // R8: bits above the count field stay zero
  a_r8_upper_zero: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (result >> CW) == '0);
  // R9: an illegal op yields a zero result
  a_r9_illegal_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && illegal) |-> result == '0);
  // R1: set top bit gives a leading count of 0
  a_r1_msb_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'b000 && src[XLEN-1]) |=> result == '0);
  // R2: set bit 0 gives a trailing count of 0
  a_r2_lsb_set: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'b001 && src[0]) |=> result == '0);
  // R3: all-zero operand gives XLEN for the leading count
  a_r3_zero_lead: assert property (@(posedge clk) disable iff (!rst_n)
    (in_valid && op == 3'b000 && src == '0) |=> result == XLEN'(XLEN));
  // R5: word leading count on a zero low word gives 32
  a_r5_word_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (XLEN == 64 && in_valid && op == 3'b100 && src[31:0] == 32'd0)
      |=> result == XLEN'(32));

endmodule

// File: tb/tb_bcnt_unit.sv
module tb_bcnt_unit;

  localparam int CLK_PERIOD = 10;
  localparam int XL = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          in_valid = 1'b0;
  logic [2:0]    op = '0;
  logic [XL-1:0] src = '0;
  logic          out_valid;
  logic [XL-1:0] result;
  logic          illegal;

  logic          v32 = 1'b0;
  logic [2:0]    op32 = '0;
  logic [31:0]   src32 = '0;
  logic          ov32;
  logic [31:0]   res32;
  logic          ill32;

  int checks = 0;
  int failures = 0;
  int cycles = 0;
  bit done = 0;

  logic [XL-1:0] exp_res_q [$];
  logic          exp_ill_q [$];
  string         tag_q [$];

  always #(CLK_PERIOD/2) clk = ~clk;

  bcnt_unit #(.XLEN(XL)) dut (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .op(op), .src(src),
    .out_valid(out_valid), .result(result), .illegal(illegal));

  bcnt_unit #(.XLEN(32)) dut32 (
    .clk(clk), .rst_n(rst_n), .in_valid(v32), .op(op32), .src(src32),
    .out_valid(ov32), .result(res32), .illegal(ill32));

  function automatic int ref_lead(logic [63:0] x, int n);
    int c = 0;
    bit hit = 0;
    for (int i = n - 1; i >= 0; i--) begin
      if (x[i]) hit = 1;
      else if (!hit) c++;
    end
    return c;
  endfunction

  function automatic int ref_trail(logic [63:0] x, int n);
    int c = 0;
    bit hit = 0;
    for (int i = 0; i < n; i++) begin
      if (x[i]) hit = 1;
      else if (!hit) c++;
    end
    return c;
  endfunction

  function automatic int ref_pop(logic [63:0] x, int n);
    int c = 0;
    for (int i = 0; i < n; i++) if (x[i]) c++;
    return c;
  endfunction

  function automatic logic [63:0] ref_expect(logic [2:0] o, logic [63:0] s,
                                             int xl, output logic ill);
    int n;
    n = o[2] ? 32 : xl;
    ill = (o[1:0] == 2'b11) || (o[2] && xl != 64);
    if (ill) return '0;
    case (o[1:0])
      2'b00:   return 64'(ref_lead(s, n));
      2'b01:   return 64'(ref_trail(s, n));
      default: return 64'(ref_pop(s, n));
    endcase
  endfunction

  function automatic string tag_of(logic [2:0] o);
    case (o)
      3'b000: return "R1";
      3'b001: return "R2";
      3'b010: return "R4";
      3'b100, 3'b101: return "R5";
      3'b110: return "R6";
      default: return "R9";
    endcase
  endfunction

  task automatic fail_line(string tag, logic [63:0] act, logic [63:0] exp);
    failures++;
    $display("FAIL %s actual=%h expected=%h", tag, act, exp);
  endtask

  task automatic drive(logic [2:0] o, logic [63:0] s, string tag);
    logic ill;
    logic [63:0] e;
    @(negedge clk);
    in_valid = 1'b1;
    op = o;
    src = s;
    e = ref_expect(o, s, XL, ill);
    exp_res_q.push_back(e);
    exp_ill_q.push_back(ill);
    tag_q.push_back(tag);
  endtask

  // Monitor: one result per cycle after each request
  always @(negedge clk) begin
    if (rst_n && out_valid) begin
      checks++;
      if (exp_res_q.size() == 0) begin
        fail_line("R10 unexpected out_valid", 64'(out_valid), 64'd0);
      end else begin
        logic [63:0] er;
        logic ei;
        string t;
        er = exp_res_q.pop_front();
        ei = exp_ill_q.pop_front();
        t  = tag_q.pop_front();
        if (result !== er || illegal !== ei)
          fail_line(t, {result[62:0], illegal}, {er[62:0], ei});
      end
    end
  end

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  endtask

  initial begin
    forever begin
      @(posedge clk);
      cycles++;
      if (cycles > 100000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected=<100000", cycles);
        finish_run();
      end
    end
  end

  initial begin
    logic [2:0] ops [6] = '{3'b000, 3'b001, 3'b010, 3'b100, 3'b101, 3'b110};
    repeat (3) @(negedge clk);
    // R10 reset state
    checks++;
    if (out_valid !== 1'b0 || result !== '0 || illegal !== 1'b0)
      fail_line("R10 reset", {result[62:0], out_valid}, 64'd0);
    @(negedge clk);
    rst_n = 1'b1;

    // Every single-bit operand under every op
    for (int k = 0; k < 6; k++)
      for (int b = 0; b < XL; b++)
        drive(ops[k], 64'd1 << b, tag_of(ops[k]));

    // R3 / R5 all-zero, R8 all-ones
    for (int k = 0; k < 6; k++) drive(ops[k], '0, "R3");
    for (int k = 0; k < 6; k++) drive(ops[k], '1, "R8");

    // Random operands
    for (int r = 0; r < 200; r++)
      for (int k = 0; k < 6; k++)
        drive(ops[k], {$urandom, $urandom}, tag_of(ops[k]));

    // R7: upper half varies, low word fixed; includes zero low word
    for (int r = 0; r < 40; r++)
      for (int k = 3; k < 6; k++)
        drive(ops[k], {$urandom, (r < 5) ? 32'd0 : 32'h0010_8000}, "R7");

    // R9 reserved kinds
    drive(3'b011, {$urandom, $urandom}, "R9");
    drive(3'b111, '1, "R9");

    @(negedge clk);
    in_valid = 1'b0;
    repeat (3) @(negedge clk);
    checks++;
    if (exp_res_q.size() != 0 || out_valid !== 1'b0)
      fail_line("R10 drain", 64'(exp_res_q.size()), 64'd0);

    // R9 word op on a 32-bit datapath
    v32 = 1'b1; op32 = 3'b100; src32 = 32'h0000_0100;
    @(negedge clk);
    checks++;
    if (ov32 !== 1'b1 || ill32 !== 1'b1 || res32 !== 32'd0)
      fail_line("R9 word op at XLEN=32", {31'd0, ill32, res32}, {31'd0, 1'b1, 32'd0});
    // R3 on the 32-bit datapath: leading count of zero is 32
    op32 = 3'b000; src32 = 32'd0;
    @(negedge clk);
    checks++;
    if (ill32 !== 1'b0 || res32 !== 32'd32)
      fail_line("R3 XLEN=32 lead", {31'd0, ill32, res32}, 64'd32);
    op32 = 3'b110; src32 = 32'hFFFF_FFFF;
    @(negedge clk);
    checks++;
    if (ill32 !== 1'b1 || res32 !== 32'd0)
      fail_line("R9 popw at XLEN=32", {31'd0, ill32, res32}, {31'd0, 1'b1, 32'd0});
    v32 = 1'b0;
    repeat (2) @(negedge clk);
    finish_run();
  end

endmodule